// File: doc/BRIEF.md
# Serial Command Frame Decoder

This block receives command frames over a two-wire serial link that has a data line and a clock line, both driven by a backplane master. It turns each frame into one access on an internal register bus. Both serial wires are brought into the system clock domain through a synchronizer. A bit is taken from the data line each time a rising edge of the serial clock is detected.

A frame is 27 bits long and is sent most-significant bit first within each field. The bits are, in order:

- a start bit of `1`;
- an 8-bit command identifier;
- a 16-bit data word;
- an odd-parity bit covering the identifier and the data;
- a stop bit of `0`.

When a frame passes both checks, the decoder produces a one-cycle write strobe, with the identifier as the address and the data word as the write data. If the identifier lies in a reserved range, the decoder produces a read strobe instead. A frame that fails the parity check or the stop-bit check produces no access. It raises a one-cycle error pulse instead.

Between frames the data line idles low. After every stop-bit slot, the decoder goes back to hunting for a start bit.

Top module: `cmd_frame_decoder`

## Requirements
- R1: While reset is asserted and right after it is released, the outputs `reg_wr_o`, `reg_rd_o` and `frame_err_o` are 0, and `reg_addr_o` and `reg_wdata_o` are all zeros.
- R2: While hunting, serial bits of value 0 are ignored. No strobe or error comes from an idle line, however many serial clock edges arrive. A frame begins at the first sampled bit of value 1.
- R3: After the start bit, the next 8 bits form the identifier and the 16 bits after those form the data word, each field MSB first. The next bit is parity and the one after it is the stop bit.
- R4: A frame passes when the count of ones over identifier, data and parity is odd and the stop bit is 0. If its identifier is outside [RD_ID_LO, RD_ID_HI], it produces `reg_wr_o` high for exactly one cycle, with `reg_addr_o` equal to the identifier and `reg_wdata_o` equal to the data word.
- R5: A passing frame whose identifier lies within [RD_ID_LO, RD_ID_HI], bounds included, produces `reg_rd_o` high for exactly one cycle with `reg_addr_o` equal to the identifier, and no write strobe.
- R6: A frame with an even count of ones over identifier, data and parity produces `frame_err_o` high for one cycle and no strobe. `reg_addr_o` and `reg_wdata_o` keep their previous values.
- R7: A frame whose stop-bit slot holds 1 produces `frame_err_o` high for one cycle and no strobe. That slot is not taken as the start of a new frame.
- R8: At most one of `reg_wr_o`, `reg_rd_o` and `frame_err_o` is high in any cycle. Each is high for no more than one cycle per frame, and `reg_addr_o` changes only together with a read or write strobe.
- R9: A start bit sent in the serial slot right after a stop bit is accepted, so frames can be sent back to back with no idle bits between them.
- R10: Data is sampled only at detected rising edges of the serial clock. A change on the data line while the serial clock stays high has no effect on the decoded frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| ser_clk_i | input | 1 | Serial link clock, asynchronous to clk |
| ser_dat_i | input | 1 | Serial link data |
| reg_addr_o | output | ID_W | Register address (command identifier) |
| reg_wdata_o | output | DATA_W | Register write data |
| reg_wr_o | output | 1 | One-cycle write strobe |
| reg_rd_o | output | 1 | One-cycle read strobe |
| frame_err_o | output | 1 | One-cycle frame error pulse |

## Verification
The bench builds the decoder with an 8-bit identifier, a 16-bit data word, a two-stage synchronizer, and a reserved read range narrowed to 0xE0 through 0xEF. That narrow range puts both of its bounds and their outside neighbours, 0xDF and 0xF0, within reach. It also lets the all-ones identifier exercise the write path. The identifiers and data words used include all-zero and all-one patterns, so the parity computation is tested at both extremes. Frames are sent back to back as well as separated by idle bits, and one frame carries data-line glitches during the high phase of the serial clock.

// File: rtl/cfd_pkg.sv
package cfd_pkg;

  // Receive state of the frame walker
  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,  // waiting for a start bit of value 1
    ST_BODY = 2'd1,  // shifting identifier, data and parity
    ST_STOP = 2'd2   // next tick carries the stop bit
  } walk_state_e;

  // Outcome of a finished frame
  typedef enum logic [1:0] {
    OUT_NONE  = 2'd0,
    OUT_WRITE = 2'd1,
    OUT_READ  = 2'd2,
    OUT_ERROR = 2'd3
  } frame_outcome_e;

endpackage

// File: rtl/cfd_bit_sync.sv
module cfd_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_clk_i,
  input  logic ser_dat_i,
  output logic tick_o,
  output logic bit_o
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] clk_pipe_q, clk_pipe_d;
  logic [STAGES-1:0] dat_pipe_q, dat_pipe_d;
  logic              clk_prev_q, clk_prev_d;

  // Next values of every synchronizer stage; stage 0 takes the raw input
  always_comb begin
    clk_pipe_d[0] = ser_clk_i;
    dat_pipe_d[0] = ser_dat_i;
    for (int i = 1; i < STAGES; i++) begin
      clk_pipe_d[i] = clk_pipe_q[i-1];
      dat_pipe_d[i] = dat_pipe_q[i-1];
    end
    clk_prev_d = clk_pipe_q[LAST];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_pipe_q <= '0;
      dat_pipe_q <= '0;
      clk_prev_q <= 1'b0;
    end else begin
      clk_pipe_q <= clk_pipe_d;
      dat_pipe_q <= dat_pipe_d;
      clk_prev_q <= clk_prev_d;
    end
  end

  // Rising edge of the synchronized serial clock; data is aligned to the same stage
  assign tick_o = clk_pipe_q[LAST] & ~clk_prev_q;
  assign bit_o  = dat_pipe_q[LAST];

endmodule

// File: rtl/cfd_frame_walker.sv
module cfd_frame_walker
  import cfd_pkg::*;
#(
  parameter int ID_W   = 8,
  parameter int DATA_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tick_i,
  input  logic                      bit_i,
  output logic                      done_o,
  output logic                      stop_o,
  output logic [ID_W+DATA_W:0]      body_o
);

  localparam int BODY_LEN = ID_W + DATA_W + 1;
  localparam int CNT_W    = $clog2(BODY_LEN);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BODY_LEN - 1);

  walk_state_e           state_q, state_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic [BODY_LEN-1:0]   body_q, body_d;
  logic                  done_q, done_d;
  logic                  stop_q, stop_d;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    body_d  = body_q;
    done_d  = 1'b0;
    stop_d  = stop_q;
    if (tick_i) begin
      unique case (state_q)
        ST_HUNT: begin
          if (bit_i) begin
            state_d = ST_BODY;
            cnt_d   = '0;
          end
        end
        ST_BODY: begin
          body_d = {body_q[BODY_LEN-2:0], bit_i};
          if (cnt_q == CNT_LAST) begin
            state_d = ST_STOP;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_STOP: begin
          // the stop slot is consumed here whatever its value
          stop_d  = bit_i;
          done_d  = 1'b1;
          state_d = ST_HUNT;
        end
        default: state_d = ST_HUNT;
      endcase
    end
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      cnt_q   <= '0;
      body_q  <= '0;
      done_q  <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      body_q  <= body_d;
      done_q  <= done_d;
      stop_q  <= stop_d;
    end
  end

  assign done_o = done_q;
  assign stop_o = stop_q;
  assign body_o = body_q;

endmodule

// File: rtl/cfd_access_gen.sv
module cfd_access_gen
  import cfd_pkg::*;
#(
  parameter int              ID_W     = 8,
  parameter int              DATA_W   = 16,
  parameter logic [ID_W-1:0] RD_ID_LO = 8'hF0,
  parameter logic [ID_W-1:0] RD_ID_HI = 8'hFF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 done_i,
  input  logic                 stop_i,
  input  logic [ID_W+DATA_W:0] body_i,
  output logic [ID_W-1:0]      addr_o,
  output logic [DATA_W-1:0]    wdata_o,
  output logic                 wr_o,
  output logic                 rd_o,
  output logic                 err_o
);

  localparam int BODY_LEN = ID_W + DATA_W + 1;

  logic [ID_W-1:0]   fr_id;
  logic [DATA_W-1:0] fr_data;
  logic              parity_ok;
  logic              in_rd_range;
  frame_outcome_e    outcome;

  logic [ID_W-1:0]   addr_q, addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic              wr_q, wr_d, rd_q, rd_d, err_q, err_d;

  assign fr_id       = body_i[BODY_LEN-1 -: ID_W];
  assign fr_data     = body_i[DATA_W:1];
  assign parity_ok   = ^body_i;             // odd count of ones over id, data, parity
  assign in_rd_range = (fr_id >= RD_ID_LO) && (fr_id <= RD_ID_HI);

  // Classify the finished frame
  always_comb begin
    outcome = OUT_NONE;
    if (done_i) begin
      if (!parity_ok || stop_i) outcome = OUT_ERROR;
      else if (in_rd_range)     outcome = OUT_READ;
      else                      outcome = OUT_WRITE;
    end
  end

  // Next-state logic of the register bus outputs
  always_comb begin
    addr_d  = addr_q;
    wdata_d = wdata_q;
    wr_d    = 1'b0;
    rd_d    = 1'b0;
    err_d   = 1'b0;
    unique case (outcome)
      OUT_WRITE: begin
        addr_d  = fr_id;
        wdata_d = fr_data;
        wr_d    = 1'b1;
      end
      OUT_READ: begin
        addr_d = fr_id;
        rd_d   = 1'b1;
      end
      OUT_ERROR: err_d = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      wr_q    <= wr_d;
      rd_q    <= rd_d;
      err_q   <= err_d;
    end
  end

  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;
  assign wr_o    = wr_q;
  assign rd_o    = rd_q;
  assign err_o   = err_q;

endmodule

// File: rtl/cmd_frame_decoder.sv
module cmd_frame_decoder #(
  parameter int              ID_W        = 8,
  parameter int              DATA_W      = 16,
  parameter int              SYNC_STAGES = 2,
  parameter logic [ID_W-1:0] RD_ID_LO    = 8'hF0,
  parameter logic [ID_W-1:0] RD_ID_HI    = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk_i,
  input  logic              ser_dat_i,
  output logic [ID_W-1:0]   reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_wr_o,
  output logic              reg_rd_o,
  output logic              frame_err_o
);

  logic                 tick;
  logic                 sbit;
  logic                 done;
  logic                 stop;
  logic [ID_W+DATA_W:0] body;

  cfd_bit_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_clk_i (ser_clk_i),
    .ser_dat_i (ser_dat_i),
    .tick_o    (tick),
    .bit_o     (sbit)
  );

  cfd_frame_walker #(
    .ID_W   (ID_W),
    .DATA_W (DATA_W)
  ) u_walk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick),
    .bit_i  (sbit),
    .done_o (done),
    .stop_o (stop),
    .body_o (body)
  );

  cfd_access_gen #(
    .ID_W     (ID_W),
    .DATA_W   (DATA_W),
    .RD_ID_LO (RD_ID_LO),
    .RD_ID_HI (RD_ID_HI)
  ) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .done_i  (done),
    .stop_i  (stop),
    .body_i  (body),
    .addr_o  (reg_addr_o),
    .wdata_o (reg_wdata_o),
    .wr_o    (reg_wr_o),
    .rd_o    (reg_rd_o),
    .err_o   (frame_err_o)
  );

endmodule

// File: rtl/cfd_checker.sv
module cfd_checker #(
  parameter int              ID_W     = 8,
  parameter int              DATA_W   = 16,
  parameter logic [ID_W-1:0] RD_ID_LO = 8'hF0,
  parameter logic [ID_W-1:0] RD_ID_HI = 8'hFF
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ID_W-1:0]   addr,
  input logic [DATA_W-1:0] wdata,
  input logic              wr,
  input logic              rd,
  input logic              err
);

  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr, rd, err}));

  a_r8_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> !wr);

  a_r8_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> !rd);

  a_r6_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);

  a_r5_rd_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    rd |-> (addr >= RD_ID_LO && addr <= RD_ID_HI));

  a_r4_wr_out_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr |-> !(addr >= RD_ID_LO && addr <= RD_ID_HI));

  a_r6_err_holds_bus: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ($stable(addr) && $stable(wdata)));

  a_r8_addr_moves_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr || rd) |-> $stable(addr));

endmodule

bind cmd_frame_decoder cfd_checker #(
  .ID_W     (ID_W),
  .DATA_W   (DATA_W),
  .RD_ID_LO (RD_ID_LO),
  .RD_ID_HI (RD_ID_HI)
) u_cfd_checker (
  .clk   (clk),
  .rst_n (rst_n),
  .addr  (reg_addr_o),
  .wdata (reg_wdata_o),
  .wr    (reg_wr_o),
  .rd    (reg_rd_o),
  .err   (frame_err_o)
);

// File: tb/cmd_frame_decoder_bench.sv
module cmd_frame_decoder_bench;

  localparam int         ID_W   = 8;
  localparam int         DATA_W = 16;
  localparam logic [7:0] RD_LO  = 8'hE0;
  localparam logic [7:0] RD_HI  = 8'hEF;
  localparam int         K_WR   = 0;
  localparam int         K_RD   = 1;
  localparam int         K_ERR  = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_clk = 1'b0;
  logic        ser_dat = 1'b0;
  logic [7:0]  addr;
  logic [15:0] wdata;
  logic        wr, rd, err;

  int n_vec = 0;
  int n_bad = 0;

  logic [25:0] exp_q[$];   // {kind[1:0], id[7:0], data[15:0]}
  string       tag_q[$];
  logic [7:0]  last_addr = '0;
  logic [15:0] last_data = '0;

  always #5 clk = ~clk;

  cmd_frame_decoder #(
    .ID_W        (ID_W),
    .DATA_W      (DATA_W),
    .SYNC_STAGES (2),
    .RD_ID_LO    (RD_LO),
    .RD_ID_HI    (RD_HI)
  ) u_cmd_frame_decoder (
    .clk         (clk),
    .rst_n       (rst_n),
    .ser_clk_i   (ser_clk),
    .ser_dat_i   (ser_dat),
    .reg_addr_o  (addr),
    .reg_wdata_o (wdata),
    .reg_wr_o    (wr),
    .reg_rd_o    (rd),
    .frame_err_o (err)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_vec++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  // Monitor: pops expectations as results appear
  always @(negedge clk) begin
    if (rst_n && (wr || rd || err)) begin
      logic [25:0] e;
      string       t;
      int          kind;
      kind = wr ? K_WR : (rd ? K_RD : K_ERR);
      check("R8 one strobe at a time", 32'(wr) + 32'(rd) + 32'(err), 32'd1);
      if (exp_q.size() == 0) begin
        check("R2 unexpected strobe on idle line", 32'(kind), 32'hFF);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({t, " kind"}, 32'(kind), 32'(e[25:24]));
        if (e[25:24] == 2'(K_ERR)) begin
          check({t, " addr held"}, 32'(addr), 32'(last_addr));
          check({t, " data held"}, 32'(wdata), 32'(last_data));
        end else begin
          check({t, " addr"}, 32'(addr), 32'(e[23:16]));
          if (e[25:24] == 2'(K_WR)) begin
            check({t, " wdata"}, 32'(wdata), 32'(e[15:0]));
            last_data = e[15:0];
          end
          last_addr = e[23:16];
        end
      end
    end
  end

  task automatic send_bit(input logic b, input bit glitch);
    @(negedge clk) ser_dat = b;
    repeat (5) @(negedge clk);
    ser_clk = 1'b1;
    repeat (3) @(negedge clk);
    if (glitch) ser_dat = ~b;   // R10: change while serial clock is high
    repeat (2) @(negedge clk);
    ser_clk = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] id, input logic [15:0] d,
                            input bit bad_par, input bit bad_stop,
                            input bit glitch, input string tag);
    logic [23:0] pay;
    logic        par;
    int          kind;
    pay = {id, d};
    par = ~(^pay) ^ bad_par;
    if (bad_par || bad_stop)          kind = K_ERR;
    else if (id >= RD_LO && id <= RD_HI) kind = K_RD;
    else                              kind = K_WR;
    exp_q.push_back({2'(kind), id, d});
    tag_q.push_back(tag);
    send_bit(1'b1, glitch);
    for (int i = 23; i >= 0; i--) send_bit(pay[i], glitch);
    send_bit(par, glitch);
    send_bit(bad_stop, glitch);
  endtask

  task automatic idle_bits(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b0, 1'b0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog expired, pending=%0d expected=0", exp_q.size());
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check("R1 strobes in reset", {29'd0, wr, rd, err}, 32'd0);
    check("R1 addr in reset", 32'(addr), 32'd0);
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 outputs after reset", {8'd0, addr, wdata}, 32'd0);
    // R2: idle zeros with clocking give nothing
    idle_bits(30);
    // R3 / R4: writes with varied patterns
    send_frame(8'h12, 16'hA5C3, 0, 0, 0, "R3 R4 write");
    idle_bits(2);
    send_frame(8'h80, 16'h0001, 0, 0, 0, "R3 R4 write msb id");
    send_frame(8'h00, 16'h0000, 0, 0, 0, "R4 all zero");
    send_frame(8'hFF, 16'hFFFF, 0, 0, 0, "R4 all ones");
    // R5: read range bounds and neighbours
    send_frame(8'hE0, 16'h1234, 0, 0, 0, "R5 read low bound");
    send_frame(8'hEF, 16'h4321, 0, 0, 0, "R5 read high bound");
    send_frame(8'hDF, 16'h5A5A, 0, 0, 0, "R5 below range writes");
    send_frame(8'hF0, 16'hC0DE, 0, 0, 0, "R5 above range writes");
    // R6: parity error
    idle_bits(3);
    send_frame(8'h33, 16'hBEEF, 1, 0, 0, "R6 parity error");
    // R7: stop-bit error, then recovery
    send_frame(8'h44, 16'h0F0F, 0, 1, 0, "R7 stop error");
    idle_bits(2);
    send_frame(8'h45, 16'h7777, 0, 0, 0, "R7 recovery write");
    // R9: back to back frames
    send_frame(8'h01, 16'h1111, 0, 0, 0, "R9 back to back a");
    send_frame(8'hE5, 16'h2222, 0, 0, 0, "R9 back to back b");
    send_frame(8'h02, 16'h3333, 0, 0, 0, "R9 back to back c");
    // R10: glitches during serial clock high
    send_frame(8'h9C, 16'h6B2D, 0, 0, 1, "R10 glitch immunity");
    idle_bits(10);
    repeat (20) @(negedge clk);
    check("R8 every frame answered", 32'(exp_q.size()), 32'd0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule